// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches sixteen external interrupt pins, decides for each one whether an event has occurred according to a programmable trigger type, and records each event in a sticky pending bit. Software sees three registers through a simple single-cycle write, registered-read bus: a trigger selection word, the pending bits and a per-line mask.

Two neighbouring lines always share one trigger field, so eight fields cover the sixteen lines. The unmasked pending bits are collapsed into three summary interrupt lines for a downstream interrupt controller. The groups have unequal sizes: lines 0 to 3, lines 4 to 11 and lines 12 to 15. The handler behind a summary line reads the pending and mask registers to find which lines need service. It acknowledges each line by writing a one to its pending bit.

Top module: `eint_ctrl`

## Requirements
- R1: Register addresses are 0 for trigger selection, 1 for pending and 2 for mask; address 3 reads as zero. `bus_rdata` shows the register addressed in a cycle after the next rising clock edge, and a write with `bus_we` high takes effect at that edge.
- R2: The trigger field of line L is the 3-bit field at bit (L/2)*4 of the trigger word, so lines 2k and 2k+1 share a field; the top bit of each nibble ignores writes and reads as 0.
- R3: Trigger codes: 000 low level, 001 high level, 010 falling edge, 100 rising edge, 110 and 111 both edges; 011 and 101 never trigger.
- R4: Each pin passes two synchroniser flops that reset to 1 (idle high); a pin change driven before clock edge P1 sets the pending bit at edge P3.
- R5: In a level mode the pending bit is set on every clock while the level is active, so a clear only sticks once the level has gone.
- R6: Writing 1 to a pending bit clears it; writing 0 leaves it unchanged.
- R7: When an event and a clear hit the same pending bit in the same cycle, the bit stays 1.
- R8: A mask bit of 1 removes that line from its summary output; pending bits still latch while masked.
- R9: `irq_grp[0]` is the OR of unmasked pending lines 0 to 3, `irq_grp[1]` lines 4 to 11 and `irq_grp[2]` lines 12 to 15, registered one clock after the pending bits.
- R10: After reset the trigger word is 0, pending is 0, mask is 0xFFFF and all summary outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 16 | External interrupt pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_grp | output | 3 | Group summary interrupts |

## Verification
The assertions assume that `rst` is applied synchronously and that the bus inputs are stable around the rising edge. The assertions on acknowledge and precedence also assume that the event vector seen by the pending register is the only source of set requests. The stimulus changes pins, write strobes and addresses only on falling clock edges, so every synchroniser and register capture is unambiguous. Level-mode cases always start from the inactive level, so a leftover active level cannot keep a pending bit alive past the clearing write.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef logic [1:0] reg_addr_t;
  localparam reg_addr_t ADDR_TRIG = 2'd0;
  localparam reg_addr_t ADDR_PEND = 2'd1;
  localparam reg_addr_t ADDR_MASK = 2'd2;

  typedef struct packed {
    logic lo;
    logic hi;
    logic fall;
    logic rise;
  } trig_sel_t;

  // Turn a 3-bit trigger code into the detectors it enables.
  function automatic trig_sel_t decode_trig(input logic [2:0] code);
    trig_sel_t t;
    t = '0;
    case (code)
      3'b000: t.lo = 1'b1;
      3'b001: t.hi = 1'b1;
      3'b010: t.fall = 1'b1;
      3'b100: t.rise = 1'b1;
      3'b110, 3'b111: begin t.fall = 1'b1; t.rise = 1'b1; end
      default: t = '0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] cur,
  output logic [N-1:0] prev
);
  logic [N-1:0] chain [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      prev_q <= '1;
    end else begin
      chain[0] <= pin;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign cur  = chain[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/eint_detect.sv
module eint_detect
  import eint_pkg::*;
#(
  parameter int N      = 16,
  parameter int CODE_W = 3,
  localparam int NPAIR = N / 2
) (
  input  logic [NPAIR*CODE_W-1:0] codes,
  input  logic [N-1:0]            cur,
  input  logic [N-1:0]            prev,
  output logic [N-1:0]            hit
);
  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int PAIR = i / 2;
    trig_sel_t sel;
    assign sel = decode_trig(codes[PAIR*CODE_W +: CODE_W]);
    assign hit[i] = (sel.lo   & ~cur[i])
                  | (sel.hi   &  cur[i])
                  | (sel.fall &  prev[i] & ~cur[i])
                  | (sel.rise & ~prev[i] &  cur[i]);
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int N       = 16,
  parameter int DATA_W  = 32,
  parameter int CODE_W  = 3,
  parameter int FIELD_W = 4,
  localparam int NPAIR  = N / 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  reg_addr_t               bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [N-1:0]            hit,
  output logic [NPAIR*CODE_W-1:0] codes,
  output logic [DATA_W-1:0]       trig_word,
  output logic [N-1:0]            pend,
  output logic [N-1:0]            mask
);
  logic [NPAIR*CODE_W-1:0] codes_q;
  logic [N-1:0] pend_q, mask_q, ack_bits;
  logic wr_trig, wr_pend, wr_mask;
  logic [NPAIR*CODE_W-1:0] codes_wr;

  assign wr_trig  = bus_we && (bus_addr == ADDR_TRIG);
  assign wr_pend  = bus_we && (bus_addr == ADDR_PEND);
  assign wr_mask  = bus_we && (bus_addr == ADDR_MASK);
  assign ack_bits = wr_pend ? bus_wdata[N-1:0] : '0;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign codes_wr[p*CODE_W +: CODE_W] = bus_wdata[p*FIELD_W +: CODE_W];
    assign trig_word[p*FIELD_W +: FIELD_W] =
      {{(FIELD_W-CODE_W){1'b0}}, codes_q[p*CODE_W +: CODE_W]};
  end
  if (DATA_W > NPAIR*FIELD_W) begin : g_pad
    assign trig_word[DATA_W-1:NPAIR*FIELD_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codes_q <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
    end else begin
      if (wr_trig) codes_q <= codes_wr;
      if (wr_mask) mask_q  <= bus_wdata[N-1:0];
      pend_q <= (pend_q & ~ack_bits) | hit;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  assign codes = codes_q;
  assign pend  = pend_q;
  assign mask  = mask_q;

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> ((pend_q & $past(bus_wdata[N-1:0] & ~hit)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int N        = 16,
  parameter int DATA_W   = 32,
  parameter int SYNC_STG = 2,
  parameter int GRP0_END = 3,
  parameter int GRP1_END = 11,
  localparam int CODE_W  = 3,
  localparam int FIELD_W = 4,
  localparam int NPAIR   = N / 2,
  localparam int NGRP    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pin_in,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NGRP-1:0]   irq_grp
);
  localparam int GRP_LO [NGRP] = '{0, GRP0_END + 1, GRP1_END + 1};
  localparam int GRP_HI [NGRP] = '{GRP0_END, GRP1_END, N - 1};

  logic [N-1:0] cur, prev, hit, pend, mask, live;
  logic [NPAIR*CODE_W-1:0] codes;
  logic [DATA_W-1:0] trig_word, rdata_q;
  logic [NGRP-1:0] irq_q;

  eint_sync #(.N(N), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_in), .cur(cur), .prev(prev));

  eint_detect #(.N(N), .CODE_W(CODE_W)) u_detect (
    .codes(codes), .cur(cur), .prev(prev), .hit(hit));

  eint_regs #(.N(N), .DATA_W(DATA_W), .CODE_W(CODE_W), .FIELD_W(FIELD_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hit(hit), .codes(codes), .trig_word(trig_word),
    .pend(pend), .mask(mask));

  assign live = pend & ~mask;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [N-1:0] SPAN =
      ({N{1'b1}} >> (N - 1 - GRP_HI[g])) & ({N{1'b1}} << GRP_LO[g]);
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= |(live & SPAN);
    end

    // R9
    grp_source_chk: assert property (@(posedge clk) disable iff (rst)
      irq_q[g] |-> $past(|(pend & ~mask & SPAN)));
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (bus_addr)
        ADDR_TRIG: rdata_q <= trig_word;
        ADDR_PEND: rdata_q <= {{(DATA_W-N){1'b0}}, pend};
        ADDR_MASK: rdata_q <= {{(DATA_W-N){1'b0}}, mask};
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_grp   = irq_q;
endmodule

// File: tb/eint_ctrl_test.sv
module eint_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] pin_in = '1;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] irq_grp;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  eint_ctrl uut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_grp(irq_grp));

  // Vector: {code[2:0], line[3:0], pin_before, pin_after}
  localparam logic [8:0] VEC [12] = '{
    {3'b000, 4'd3,  1'b1, 1'b0}, {3'b000, 4'd4,  1'b1, 1'b1},
    {3'b001, 4'd5,  1'b0, 1'b1}, {3'b001, 4'd0,  1'b0, 1'b0},
    {3'b010, 4'd6,  1'b1, 1'b0}, {3'b010, 4'd7,  1'b0, 1'b1},
    {3'b100, 4'd8,  1'b0, 1'b1}, {3'b100, 4'd9,  1'b1, 1'b0},
    {3'b110, 4'd10, 1'b0, 1'b1}, {3'b111, 4'd11, 1'b1, 1'b0},
    {3'b011, 4'd12, 1'b0, 1'b1}, {3'b101, 4'd13, 1'b1, 1'b0}
  };

  function automatic logic fires(input logic [2:0] c, input logic b, input logic a);
    case (c)
      3'b000: return !a;
      3'b001: return a;
      3'b010: return b && !a;
      3'b100: return !b && a;
      3'b110, 3'b111: return b != a;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] grp_of(input int line);
    if (line <= 3) return 3'b001;
    if (line <= 11) return 3'b010;
    return 3'b100;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    @(negedge clk) rst = 1'b0;
    idle(2);

    // R10 reset state
    chk("R10 irq", {29'b0, irq_grp}, 32'h0);
    rd(2'd0, d); chk("R10 trig", d, 32'h0);
    rd(2'd1, d); chk("R10 pend", d, 32'h0);
    rd(2'd2, d); chk("R10 mask", d, 32'h0000_FFFF);
    // R1 unused address
    rd(2'd3, d); chk("R1 addr3", d, 32'h0);

    // R3 trigger table walk
    for (int v = 0; v < 12; v++) begin
      logic [2:0] code;
      int line;
      logic b, a;
      code = VEC[v][8:6]; line = int'(VEC[v][5:2]); b = VEC[v][1]; a = VEC[v][0];
      wr(2'd0, {8{1'b0, code}});
      set_pins({16{b}});
      idle(4);
      wr(2'd1, 32'hFFFF);
      idle(4);
      @(negedge clk) pin_in[line] = a;
      idle(4);
      rd(2'd1, d);
      chk("R3 vector", d, 32'(fires(code, b, a)) << line);
    end

    // R2 field layout and shared pair
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 unused bits", d, 32'h7777_7777);
    wr(2'd0, 32'h3333_3433);
    set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF);
    set_pins(16'h0020); idle(4);
    rd(2'd1, d); chk("R2 line5", d, 32'h0020);
    wr(2'd1, 32'hFFFF);
    set_pins(16'h0070); idle(4);
    rd(2'd1, d); chk("R2 line4 shares, line6 none", d, 32'h0010);

    // R6 write-one-to-clear
    wr(2'd0, 32'h4444_4444);
    set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF);
    set_pins(16'h0006); idle(4);
    rd(2'd1, d); chk("R6 set", d, 32'h0006);
    wr(2'd1, 32'h0000);
    rd(2'd1, d); chk("R6 zero write", d, 32'h0006);
    wr(2'd1, 32'h0002);
    rd(2'd1, d); chk("R6 one write", d, 32'h0004);

    // R7 event and clear in the same cycle
    set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF);
    set_pins(16'h4000); idle(4);
    set_pins(16'h0000); idle(4);
    @(negedge clk) pin_in[14] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h4000; end
    @(negedge clk) bus_we = 1'b0;
    rd(2'd1, d); chk("R7 set wins", d, 32'h4000);
    wr(2'd1, 32'h4000);
    rd(2'd1, d); chk("R7 later clear", d, 32'h0);

    // R5 level persists through clear
    wr(2'd0, 32'h1111_1111);
    set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF);
    set_pins(16'h0200); idle(4);
    wr(2'd1, 32'hFFFF);
    rd(2'd1, d); chk("R5 level held", d, 32'h0200);
    set_pins(16'h0000); idle(4);
    wr(2'd1, 32'hFFFF);
    rd(2'd1, d); chk("R5 level gone", d, 32'h0);

    // R4 latency to pending and R9 registered summary
    wr(2'd0, 32'h4444_4444);
    wr(2'd2, 32'hFFFE);
    set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF); idle(1);
    @(negedge clk) pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R4 summary not yet", {29'b0, irq_grp}, 32'h0);
    @(negedge clk);
    chk("R4 R9 summary after pending", {29'b0, irq_grp}, 32'h1);

    // R9 grouping and R8 masking
    wr(2'd2, 32'h0000);
    foreach (VEC[k]) begin
      if (k < 4) begin
        int line;
        line = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 11 : 12;
        wr(2'd2, 32'h0000);
        set_pins(16'h0000); idle(4); wr(2'd1, 32'hFFFF); idle(2);
        @(negedge clk) pin_in[line] = 1'b1;
        idle(5);
        chk("R9 group", {29'b0, irq_grp}, {29'b0, grp_of(line)});
        wr(2'd2, 32'hFFFF); idle(2);
        chk("R8 masked summary", {29'b0, irq_grp}, 32'h0);
        rd(2'd1, d); chk("R8 pending kept", d, 32'h1 << line);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule